// File: doc/BRIEF.md
# Shared-Buffer Switch Module with Hysteresis Backpressure

This block is one switching element of a larger fabric. It has a configurable number of input and output ports. On each time slot, which is one clock cycle, every input may present one fixed-size cell. A cell carries a destination output index, a priority class and a data word. Accepted cells are stored in a single shared pool of slots. Inside the pool, the cells are chained into per-queue linked lists, one list for each combination of input, destination and class. On every slot, each output sends the highest-class cell that is waiting for it. Ties among inputs inside that class go to a per-output round-robin pointer.

The module keeps a count for each input of the cells that arrived on that input and are still resident. From this count it drives a backpressure flag back to the upstream sender. The flag is set at an upper threshold and cleared only at a lower threshold, so it switches with hysteresis. Because outputs serve strictly by class, low-class cells from one input can stay resident for a long time and keep that input blocked. An arrival offered while its input is backpressured is a protocol violation. Such a cell is dropped and reported on a per-input error flag.

Top module: `shared_buf_switch`

## Requirements
- R1: The resident count of an input rises by one for each cell accepted on that input and falls by one for each of its cells that departs. Both changes take effect at the clock edge where the event happens.
- R2: `bp_o[i]` is 1 from the edge at which input i's count becomes greater than or equal to `HI_TH` (default 5).
- R3: `bp_o[i]` returns to 0 only at the edge at which the count becomes less than or equal to `LO_TH` (default 4). While the count lies strictly between the two thresholds, the previous value is held.
- R4: A cell presented on input i while `bp_o[i]` is 1 is discarded and never appears on any output. `proto_err_o[i]` is 1 for the one cycle after that edge.
- R5: Class values are numeric, and a larger value means a higher priority. Each output serves only cells of the highest class that is waiting for it from any input.
- R6: Within the winning class, an output serves the first waiting input at or after its pointer, wrapping after input N_IN-1. The pointer then moves to the served input plus one, modulo N_IN. All pointers are 0 after reset.
- R7: Cells from the same input to the same output with the same class leave in arrival order.
- R8: A cell accepted at edge k with no competition appears on its output for exactly the one cycle after edge k+1.
- R9: After reset, every backpressure flag, output valid bit and error flag is 0, and the pool is empty.
- R10: An output beat carries the cell's source input on `out_src_o`, its class on `out_cls_o` and its data on `out_data_o`. Field d of a flattened vector occupies bits [d*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_IN | A cell is offered on input i |
| in_dest_i | input | N_IN*DST_W | Destination output index per input |
| in_cls_i | input | N_IN*CLS_W | Priority class per input (larger is higher) |
| in_data_i | input | N_IN*DATA_W | Cell data per input |
| bp_o | output | N_IN | Backpressure to the upstream sender per input |
| proto_err_o | output | N_IN | Arrival was refused at the previous edge |
| out_valid_o | output | N_OUT | A cell leaves on output d this cycle |
| out_src_o | output | N_OUT*SRC_W | Source input of the departing cell |
| out_cls_o | output | N_OUT*CLS_W | Class of the departing cell |
| out_data_o | output | N_OUT*DATA_W | Data of the departing cell |

## Verification
A cell is stored at the edge where it is offered and leaves through the output register one edge later. The bench therefore expects an uncontested cell one full step after it stores it, and expects a competing cell one step later for each cell served ahead of it. Backpressure and the error flag are registered at the same edge that changes the count. They are checked right after that edge, and the hold and release steps are checked at the edges where the draining output removes one cell. Inputs are driven and outputs are sampled at the falling edge, so each check reads registers settled by exactly the rising edges counted.

// File: rtl/shared_buf_pkg.sv
package shared_buf_pkg;
  // flat index of the queue for (input, output, class)
  function automatic int q_index(input int src, input int dst, input int cls,
                                 input int n_out, input int n_cls);
    return (src * n_out + dst) * n_cls + cls;
  endfunction
endpackage

// File: rtl/sb_bp_ctrl.sv
module sb_bp_ctrl #(
  parameter int CNT_W = 5,
  parameter int DEC_W = 3,
  parameter int HI_TH = 5,
  parameter int LO_TH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [DEC_W-1:0] dec_i,
  output logic             bp_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             bp_q, bp_nxt;

  always_comb begin
    cnt_nxt = cnt_q + CNT_W'(inc_i) - CNT_W'(dec_i);
    bp_nxt  = bp_q;
    if (cnt_nxt >= CNT_W'(HI_TH))      bp_nxt = 1'b1;
    else if (cnt_nxt <= CNT_W'(LO_TH)) bp_nxt = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      bp_q  <= bp_nxt;
    end
  end

  assign bp_o = bp_q;

  p_no_underflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CNT_W+1)'(dec_i) <= (CNT_W+1)'(cnt_q) + (CNT_W+1)'(inc_i));
  p_bp_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= CNT_W'(HI_TH)) |-> bp_q);
  p_bp_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= CNT_W'(LO_TH)) |-> !bp_q);
  p_bp_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > CNT_W'(LO_TH) && cnt_q < CNT_W'(HI_TH) &&
     $past(cnt_q) > CNT_W'(LO_TH) && $past(cnt_q) < CNT_W'(HI_TH)) |-> $stable(bp_q));
endmodule

// File: rtl/sb_alloc.sv
module sb_alloc #(
  parameter int N_IN  = 4,
  parameter int DEPTH = 20,
  parameter int PTR_W = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IN-1:0]       req_i,
  input  logic [DEPTH-1:0]      rel_i,
  output logic [N_IN-1:0]       ok_o,
  output logic [N_IN*PTR_W-1:0] slot_o
);
  logic [DEPTH-1:0] free_q, avail, taken;

  // each requester takes the lowest free slot left by the ones before it
  always_comb begin
    avail  = free_q;
    taken  = '0;
    ok_o   = '0;
    slot_o = '0;
    for (int i = 0; i < N_IN; i++) begin
      for (int s = 0; s < DEPTH; s++) begin
        if (!ok_o[i] && avail[s]) begin
          ok_o[i]                 = 1'b1;
          slot_o[i*PTR_W +: PTR_W] = PTR_W'(s);
        end
      end
      if (ok_o[i] && req_i[i]) begin
        avail[slot_o[i*PTR_W +: PTR_W]] = 1'b0;
        taken[slot_o[i*PTR_W +: PTR_W]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '1;
    else         free_q <= (free_q & ~taken) | rel_i;
  end

  p_no_double_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i & free_q) == '0);
endmodule

// File: rtl/sb_out_sched.sv
module sb_out_sched #(
  parameter int N_IN  = 4,
  parameter int N_CLS = 3,
  parameter int SRC_W = 2,
  parameter int CLS_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IN*N_CLS-1:0] req_i,
  output logic                  gnt_vld_o,
  output logic [SRC_W-1:0]      gnt_src_o,
  output logic [CLS_W-1:0]      gnt_cls_o
);
  logic [SRC_W-1:0] ptr_q;
  logic             found, higher_req;
  int               idx;

  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_cls_o = '0;
    for (int c = 0; c < N_CLS; c++) begin
      for (int i = 0; i < N_IN; i++) begin
        if (req_i[i*N_CLS + c]) begin
          gnt_vld_o = 1'b1;
          gnt_cls_o = CLS_W'(c);
        end
      end
    end
    found     = 1'b0;
    gnt_src_o = '0;
    idx       = 0;
    for (int k = 0; k < N_IN; k++) begin
      idx = (int'(ptr_q) + k) % N_IN;
      if (!found && req_i[idx*N_CLS + int'(gnt_cls_o)]) begin
        found     = 1'b1;
        gnt_src_o = SRC_W'(idx);
      end
    end
  end

  // checker view: any request above the granted class
  always_comb begin
    higher_req = 1'b0;
    for (int i = 0; i < N_IN; i++)
      for (int c = 0; c < N_CLS; c++)
        if (c > int'(gnt_cls_o) && req_i[i*N_CLS + c]) higher_req = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (gnt_vld_o) ptr_q <= SRC_W'((int'(gnt_src_o) + 1) % N_IN);
  end

  p_strict_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> !higher_req);
  p_grant_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> req_i[int'(gnt_src_o)*N_CLS + int'(gnt_cls_o)]);
endmodule

// File: rtl/shared_buf_switch.sv
module shared_buf_switch
  import shared_buf_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int N_CLS  = 3,
  parameter int DEPTH  = 20,
  parameter int DATA_W = 8,
  parameter int HI_TH  = 5,
  parameter int LO_TH  = 4,
  localparam int DST_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int SRC_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int CLS_W = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IN-1:0]         in_valid_i,
  input  logic [N_IN*DST_W-1:0]   in_dest_i,
  input  logic [N_IN*CLS_W-1:0]   in_cls_i,
  input  logic [N_IN*DATA_W-1:0]  in_data_i,
  output logic [N_IN-1:0]         bp_o,
  output logic [N_IN-1:0]         proto_err_o,
  output logic [N_OUT-1:0]        out_valid_o,
  output logic [N_OUT*SRC_W-1:0]  out_src_o,
  output logic [N_OUT*CLS_W-1:0]  out_cls_o,
  output logic [N_OUT*DATA_W-1:0] out_data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DEC_W = $clog2(N_OUT + 1);
  localparam int NQ    = N_IN * N_OUT * N_CLS;

  logic [N_IN-1:0]             req, acc, a_ok;
  logic [N_IN*PTR_W-1:0]       a_slot;
  logic [DEPTH-1:0]            rel;
  logic [N_IN-1:0][DEC_W-1:0]  dec_n;
  logic [N_OUT-1:0]            g_vld;
  logic [N_OUT-1:0][SRC_W-1:0] g_src;
  logic [N_OUT-1:0][CLS_W-1:0] g_cls;
  logic [N_OUT-1:0][PTR_W-1:0] sel_slot;
  logic [N_OUT-1:0][N_IN*N_CLS-1:0] sreq;

  logic [NQ-1:0]    q_nempty, pop, push, link_we;
  logic [PTR_W-1:0] q_head [NQ];
  logic [PTR_W-1:0] q_tail [NQ];
  logic [PTR_W-1:0] push_slot [NQ];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [PTR_W-1:0]  next_mem [DEPTH];
  logic [N_IN-1:0]   err_q;

  assign req = in_valid_i & ~bp_o;
  assign acc = req & a_ok;

  for (genvar i = 0; i < N_IN; i++) begin : g_port
    sb_bp_ctrl #(.CNT_W(CNT_W), .DEC_W(DEC_W), .HI_TH(HI_TH), .LO_TH(LO_TH)) u_bp (
      .clk_i (clk_i), .rst_ni(rst_ni), .inc_i(acc[i]), .dec_i(dec_n[i]), .bp_o(bp_o[i]));
  end

  sb_alloc #(.N_IN(N_IN), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_alloc (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .rel_i(rel), .ok_o(a_ok), .slot_o(a_slot));

  for (genvar d = 0; d < N_OUT; d++) begin : g_out
    for (genvar i = 0; i < N_IN; i++) begin : g_src_req
      for (genvar c = 0; c < N_CLS; c++) begin : g_cls_req
        assign sreq[d][i*N_CLS + c] = q_nempty[q_index(i, d, c, N_OUT, N_CLS)];
      end
    end
    sb_out_sched #(.N_IN(N_IN), .N_CLS(N_CLS), .SRC_W(SRC_W), .CLS_W(CLS_W)) u_sched (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(sreq[d]),
      .gnt_vld_o(g_vld[d]), .gnt_src_o(g_src[d]), .gnt_cls_o(g_cls[d]));
  end

  // queue push/pop requests, slot release and per-input departure counts
  always_comb begin
    int qs, qa;
    pop      = '0;
    push     = '0;
    rel      = '0;
    dec_n    = '0;
    link_we  = '0;
    sel_slot = '0;
    for (int q = 0; q < NQ; q++) push_slot[q] = '0;
    for (int d = 0; d < N_OUT; d++) begin
      qs          = q_index(int'(g_src[d]), d, int'(g_cls[d]), N_OUT, N_CLS);
      sel_slot[d] = q_head[qs];
      if (g_vld[d]) begin
        pop[qs]            = 1'b1;
        rel[q_head[qs]]    = 1'b1;
        dec_n[g_src[d]]    = dec_n[g_src[d]] + DEC_W'(1);
      end
    end
    for (int i = 0; i < N_IN; i++) begin
      qa = q_index(i, int'(in_dest_i[i*DST_W +: DST_W]),
                   int'(in_cls_i[i*CLS_W +: CLS_W]), N_OUT, N_CLS);
      if (acc[i]) begin
        push[qa]      = 1'b1;
        push_slot[qa] = a_slot[i*PTR_W +: PTR_W];
      end
    end
    for (int q = 0; q < NQ; q++)
      link_we[q] = push[q] && q_nempty[q] && !(pop[q] && q_head[q] == q_tail[q]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_nempty <= '0;
      for (int q = 0; q < NQ; q++) begin
        q_head[q] <= '0;
        q_tail[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (pop[q]) begin
          if (q_head[q] == q_tail[q]) begin
            if (push[q]) begin
              q_head[q] <= push_slot[q];
              q_tail[q] <= push_slot[q];
            end else begin
              q_nempty[q] <= 1'b0;
            end
          end else begin
            q_head[q] <= next_mem[q_head[q]];
            if (push[q]) q_tail[q] <= push_slot[q];
          end
        end else if (push[q]) begin
          if (!q_nempty[q]) begin
            q_head[q]   <= push_slot[q];
            q_nempty[q] <= 1'b1;
          end
          q_tail[q] <= push_slot[q];
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N_IN; i++)
      if (acc[i]) data_mem[a_slot[i*PTR_W +: PTR_W]] <= in_data_i[i*DATA_W +: DATA_W];
    for (int q = 0; q < NQ; q++)
      if (link_we[q]) next_mem[q_tail[q]] <= push_slot[q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= '0;
      out_src_o   <= '0;
      out_cls_o   <= '0;
      out_data_o  <= '0;
      err_q       <= '0;
    end else begin
      out_valid_o <= g_vld;
      err_q       <= in_valid_i & ~acc;
      for (int d = 0; d < N_OUT; d++) begin
        out_src_o[d*SRC_W +: SRC_W]    <= g_src[d];
        out_cls_o[d*CLS_W +: CLS_W]    <= g_cls[d];
        out_data_o[d*DATA_W +: DATA_W] <= data_mem[sel_slot[d]];
      end
    end
  end

  assign proto_err_o = err_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    p_err_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i[i] && bp_o[i]) |=> proto_err_o[i]);
    p_err_only_offered_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proto_err_o[i] |-> $past(in_valid_i[i]));
  end
  p_pop_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop & ~q_nempty) == '0);
endmodule

// File: tb/sim_shared_buf_switch.sv
module sim_shared_buf_switch;
  localparam int NI = 4, NO = 4, NC = 3, DW = 8, HI = 5, LO = 3;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [NI-1:0]    in_valid;
  logic [NI*2-1:0]  in_dest, in_cls;
  logic [NI*DW-1:0] in_data;
  logic [NI-1:0]    bp, perr;
  logic [NO-1:0]    out_valid;
  logic [NO*2-1:0]  out_src, out_cls;
  logic [NO*DW-1:0] out_data;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  shared_buf_switch #(.N_IN(NI), .N_OUT(NO), .N_CLS(NC), .DEPTH(20), .DATA_W(DW),
                      .HI_TH(HI), .LO_TH(LO)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_dest_i(in_dest),
    .in_cls_i(in_cls), .in_data_i(in_data), .bp_o(bp), .proto_err_o(perr),
    .out_valid_o(out_valid), .out_src_o(out_src), .out_cls_o(out_cls), .out_data_o(out_data));

  // src, dest, cls, data
  localparam logic [13:0] VEC [4] = '{
    {2'd0, 2'd2, 2'd1, 8'hA5},
    {2'd3, 2'd0, 2'd2, 8'h3C},
    {2'd2, 2'd1, 2'd0, 8'h5A},
    {2'd1, 2'd3, 2'd1, 8'hC3}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    in_valid = '0; in_dest = '0; in_cls = '0; in_data = '0;
  endtask

  task automatic put(input int i, input int d, input int c, input int v);
    in_valid[i]         = 1'b1;
    in_dest[i*2 +: 2]   = 2'(d);
    in_cls[i*2 +: 2]    = 2'(c);
    in_data[i*DW +: DW] = DW'(v);
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk_out(input string tag, input int d, input int src, input int cls, input int v);
    check({tag, " valid"}, int'(out_valid[d]), 1);
    check({tag, " src"},   int'(out_src[d*2 +: 2]), src);
    check({tag, " cls"},   int'(out_cls[d*2 +: 2]), cls);
    check({tag, " data"},  int'(out_data[d*DW +: DW]), v);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int rr_exp [6];
    int hp_exp [3];
    rr_exp = '{3, 1, 2, 6, 4, 5};
    hp_exp = '{8'h22, 8'h33, 8'h11};
    clr();
    rst_ni = 1'b0;
    repeat (3) step();
    check("R9 bp after reset", int'(bp), 0);
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 proto_err after reset", int'(perr), 0);
    rst_ni = 1'b1;
    step();

    // R8 R10: single cells routed with their fields, one-slot latency
    for (int k = 0; k < 4; k++) begin
      int s, d, c, v;
      {s, d, c, v} = {30'd0, VEC[k][13:12], 30'd0, VEC[k][11:10], 30'd0, VEC[k][9:8], 24'd0, VEC[k][7:0]};
      clr(); put(s, d, c, v);
      step();
      clr();
      check("R8 no output at store edge", int'(out_valid), 0);
      step();
      check("R10 only dest output valid", int'(out_valid), 1 << d);
      chk_out("R10 vector", d, s, c, v);
      step();
      check("R8 single beat", int'(out_valid), 0);
    end

    // R5: three classes to output 1 in the same slot
    clr(); put(0, 1, 0, 8'h11); put(1, 1, 2, 8'h22); put(2, 1, 1, 8'h33);
    step(); clr();
    for (int k = 0; k < 3; k++) begin
      step();
      check("R5 priority order data", int'(out_data[1*DW +: DW]), hp_exp[k]);
      check("R5 priority order valid", int'(out_valid[1]), 1);
    end
    step();

    // R6 R7: equal class to output 3, pointer at 2 after the vector run
    for (int t = 0; t < 2; t++) begin
      clr();
      for (int i = 0; i < 3; i++) put(i, 3, 1, 1 + i + 3*t);
      step();
    end
    clr();
    check("R6 first pick", int'(out_data[3*DW +: DW]), rr_exp[0]);
    for (int k = 1; k < 6; k++) begin
      step();
      check("R6 R7 round-robin order", int'(out_data[3*DW +: DW]), rr_exp[k]);
    end
    step();
    check("R6 drained", int'(out_valid[3]), 0);

    // R1 R2: input 0 low class blocked behind input 1 high class on output 0
    for (int t = 0; t < 5; t++) begin
      clr(); put(0, 0, 0, 8'h40 + t); put(1, 0, 2, 8'h80 + t);
      step();
      check("R2 bp0 rise at count five", int'(bp[0]), (t == 4) ? 1 : 0);
      check("R1 bp1 stays low", int'(bp[1]), 0);
      if (t > 0) chk_out("R5 high class first", 0, 1, 2, 8'h80 + t - 1);
    end
    // R4: violating arrival while bp0 is set
    clr(); put(0, 1, 2, 8'hEE);
    step(); clr();
    check("R4 proto_err set", int'(perr[0]), 1);
    check("R2 bp0 still set", int'(bp[0]), 1);
    chk_out("R5 last high cell", 0, 1, 2, 8'h84);
    step();
    check("R4 proto_err one cycle", int'(perr[0]), 0);
    check("R4 dropped cell absent", int'(out_valid[1]), 0);
    chk_out("R7 drain 0", 0, 0, 0, 8'h40);
    check("R3 bp0 held at count four", int'(bp[0]), 1);
    step();
    chk_out("R7 drain 1", 0, 0, 0, 8'h41);
    check("R3 R1 bp0 released at count three", int'(bp[0]), 0);
    for (int k = 2; k < 5; k++) begin
      step();
      chk_out("R7 drain", 0, 0, 0, 8'h40 + k);
    end
    step();
    check("R1 pool empty output idle", int'(out_valid), 0);
    check("R4 no stray errors", int'(perr), 0);
    finish_run();
  end
endmodule